// File: doc/BRIEF.md
# RAM Size Probe Engine

This block runs straight out of reset and discovers how much memory is fitted below the top of a 16-bit address space. It probes one 256-byte page at a time, moving upward, and stops at the first page that fails to store and return data correctly. The last page that passed is reported as the top usable page, together with a done flag.

Each page is probed at its byte offset zero with two complementary patterns. Between every pattern write and its read-back, the engine performs a read-modify-write at address zero: it reads the byte, writes it back unchanged, then writes it plus one. Those three accesses overwrite any charge the write left on an unterminated data bus. They also change the byte at address zero, so a decoder that folds high pages onto zero page cannot return the pattern. The bus is a simple synchronous one. A request carries a write enable, an address and write data. Read data comes back one cycle after the read request.

After the result is reported, the engine holds it and leaves the bus idle. A start pulse re-runs the whole probe from the first page.

Top module: `mem_size_probe`

## Requirements
- R1: After reset is released, the first bus access is a write of 0xAA to address 0x1800. The page pointer resets to 0x17 and is incremented before each probe, and every probe address is {page, 8'h00}.
- R2: At most one access is issued per cycle, mem_we_o is only high with mem_req_o, and the cycle after a read request carries no request. Read data is taken from mem_rdata_i in that following cycle.
- R3: Between each pattern write and its read-back there are exactly three accesses to 0x0000, in this order: a read, a write of the value read, and a write of that value plus one modulo 256. The read-back of the probe address follows directly.
- R4: The 0xAA pattern is tested first. If it mismatches, probing stops and 0x55 is never written to that page. If it matches, 0x55 is written and checked at the same address. The engine moves to the next page only when both patterns match.
- R5: When a probe fails, top_page_o becomes the failing page minus one and done_o rises. If page 0x18 fails, top_page_o is 0x17.
- R6: If page 0xFF passes both patterns, the engine stops without wrapping and reports 0xFF. No further access is issued after the last read-back of page 0xFF.
- R7: While done_o is high and start_i is low, done_o and top_page_o hold their values and mem_req_o stays low.
- R8: start_i high while done_o is high drops done_o at the next clock edge and re-runs the probe from page 0x18.
- R9: When unfitted pages return whatever value was last driven on the data bus, the reported top is the last fitted page.
- R10: When a decode fault maps pages from some base upward onto zero page, the reported top is the page just below that base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; the probe starts when it is released |
| start_i | input | 1 | Re-runs the probe when sampled high while done |
| mem_req_o | output | 1 | Bus access request |
| mem_we_o | output | 1 | Write enable for the access |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read request |
| done_o | output | 1 | Probe finished; the result is valid |
| top_page_o | output | 8 | Highest page that passed both patterns |

## Verification
The bench runs a memory model in which unfitted pages echo the last driven bus value. Without the zero-page read-modify-write, the probe would report every page as fitted. An aliasing fault is modelled by mapping high pages onto zero page. A design that skipped or misordered the three zero-page accesses would report 0xFF here instead of the page below the fault. A stuck bit that only the 0x55 pattern exposes catches a design that checks one pattern only. A fully fitted map catches a pointer that wraps past 0xFF, because that design makes extra zero-address writes. A memory fitted only up to 0x17 catches a failure report that is off by one.

// File: rtl/mem_size_probe_pkg.sv
package mem_size_probe_pkg;
  typedef enum logic [3:0] {
    ST_STEP,
    ST_WPAT,
    ST_ZRD,
    ST_ZCAP,
    ST_ZOLD,
    ST_ZINC,
    ST_RPAT,
    ST_RCAP,
    ST_CHK,
    ST_DONE
  } probe_state_e;
endpackage

// File: rtl/probe_page_ptr.sv
module probe_page_ptr #(
  parameter int unsigned PAGE_W = 8,
  parameter logic [PAGE_W-1:0] START_PAGE = 8'h17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              last_o
);
  localparam logic [PAGE_W-1:0] LAST_PAGE = '1;

  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     page_q <= START_PAGE;
    else if (load_i) page_q <= START_PAGE;
    else if (step_i) page_q <= page_q + 1'b1;
  end

  assign page_o = page_q;
  assign last_o = (page_q == LAST_PAGE);

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (page_q != LAST_PAGE)); // R6
endmodule

// File: rtl/probe_rd_cap.sv
module probe_rd_cap #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zp_en_i,
  input  logic              rb_en_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] pat_i,
  output logic [DATA_W-1:0] zp_o,
  output logic              match_o
);
  logic [DATA_W-1:0] zp_q, rb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zp_q <= '0;
      rb_q <= '0;
    end else begin
      if (zp_en_i) zp_q <= rdata_i;
      if (rb_en_i) rb_q <= rdata_i;
    end
  end

  assign zp_o    = zp_q;
  assign match_o = (rb_q == pat_i);

  AST_ONE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(zp_en_i && rb_en_i)); // R2
endmodule

// File: rtl/probe_fsm.sv
module probe_fsm
  import mem_size_probe_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFF_W  = 8,
  parameter logic [DATA_W-1:0] PAT_A = 8'hAA,
  parameter logic [ADDR_W-1:0] TRIP_ADDR = '0,
  localparam int unsigned PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              last_i,
  input  logic              match_i,
  input  logic [DATA_W-1:0] zp_i,
  output logic              load_o,
  output logic              step_o,
  output logic              zp_en_o,
  output logic              rb_en_o,
  output logic [DATA_W-1:0] pat_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o,
  output logic [PAGE_W-1:0] top_o
);
  localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;

  probe_state_e      state_q;
  logic              pat_sel_q;
  logic              done_q;
  logic [PAGE_W-1:0] top_q;
  logic [ADDR_W-1:0] probe_addr;

  assign probe_addr = {page_i, {OFF_W{1'b0}}};
  assign pat_o      = pat_sel_q ? PAT_B : PAT_A;
  assign step_o     = (state_q == ST_STEP);
  assign load_o     = (state_q == ST_DONE) && start_i;
  assign zp_en_o    = (state_q == ST_ZCAP);
  assign rb_en_o    = (state_q == ST_RCAP);
  assign done_o     = done_q;
  assign top_o      = top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_STEP;
      pat_sel_q <= 1'b0;
      done_q    <= 1'b0;
      top_q     <= '0;
    end else begin
      unique case (state_q)
        ST_STEP: state_q <= ST_WPAT;
        ST_WPAT: state_q <= ST_ZRD;
        ST_ZRD:  state_q <= ST_ZCAP;
        ST_ZCAP: state_q <= ST_ZOLD;
        ST_ZOLD: state_q <= ST_ZINC;
        ST_ZINC: state_q <= ST_RPAT;
        ST_RPAT: state_q <= ST_RCAP;
        ST_RCAP: state_q <= ST_CHK;
        ST_CHK: begin
          if (!match_i) begin
            top_q   <= page_i - 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end else if (!pat_sel_q) begin
            pat_sel_q <= 1'b1;
            state_q   <= ST_WPAT;
          end else if (last_i) begin
            top_q   <= page_i;
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            pat_sel_q <= 1'b0;
            state_q   <= ST_STEP;
          end
        end
        ST_DONE: begin
          if (start_i) begin
            done_q    <= 1'b0;
            pat_sel_q <= 1'b0;
            state_q   <= ST_STEP;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  // one access per state; trip address gets read, old value, old value + 1
  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (state_q)
      ST_WPAT: begin req_o = 1'b1; we_o = 1'b1; addr_o = probe_addr; wdata_o = pat_o; end
      ST_ZRD:  begin req_o = 1'b1; addr_o = TRIP_ADDR; end
      ST_ZOLD: begin req_o = 1'b1; we_o = 1'b1; addr_o = TRIP_ADDR; wdata_o = zp_i; end
      ST_ZINC: begin req_o = 1'b1; we_o = 1'b1; addr_o = TRIP_ADDR; wdata_o = zp_i + 1'b1; end
      ST_RPAT: begin req_o = 1'b1; addr_o = probe_addr; end
      default: ;
    endcase
  end

  AST_PAT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o && addr_o != TRIP_ADDR && wdata_o == PAT_B) |->
      ($past(state_q) == ST_CHK && $past(match_i))); // R4
  AST_FAIL_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) && !$past(match_i) |-> top_q == $past(page_i) - 1'b1); // R5
endmodule

// File: rtl/mem_size_probe.sv
module mem_size_probe #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFF_W  = 8,
  parameter logic [ADDR_W-OFF_W-1:0] START_PAGE = 8'h17,
  parameter logic [DATA_W-1:0] PAT_A = 8'hAA,
  localparam int unsigned PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [PAGE_W-1:0] top_page_o
);
  localparam logic [ADDR_W-1:0] TRIP_ADDR = '0;

  logic              load, step, last, match, zp_en, rb_en;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] zp_val, pat;

  probe_page_ptr #(.PAGE_W(PAGE_W), .START_PAGE(START_PAGE)) u_ptr (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .page_o(page), .last_o(last)
  );

  probe_rd_cap #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .zp_en_i(zp_en), .rb_en_i(rb_en), .rdata_i(mem_rdata_i),
    .pat_i(pat), .zp_o(zp_val), .match_o(match)
  );

  probe_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .PAT_A(PAT_A), .TRIP_ADDR(TRIP_ADDR)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .page_i(page), .last_i(last), .match_i(match),
    .zp_i(zp_val), .load_o(load), .step_o(step), .zp_en_o(zp_en), .rb_en_o(rb_en),
    .pat_o(pat), .req_o(mem_req_o), .we_o(mem_we_o), .addr_o(mem_addr_o),
    .wdata_o(mem_wdata_o), .done_o(done_o), .top_o(top_page_o)
  );

  AST_WE_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o); // R2
  AST_READ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !mem_req_o); // R2
  AST_TRIP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_addr_o == TRIP_ADDR &&
     $past(mem_req_o && mem_we_o && mem_addr_o == TRIP_ADDR))
      |-> mem_wdata_o == $past(mem_wdata_o) + 1'b1); // R3
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o); // R7
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(top_page_o))); // R7
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> !done_o); // R8
endmodule

// File: tb/sim_mem_size_probe.sv
module sim_mem_size_probe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req, we, done;
  logic [15:0] addr;
  logic [7:0]  wdata, top;
  logic [7:0]  rdata = 8'h00;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // memory model configuration
  logic [7:0] pop_top   = 8'hFF;
  logic       alias_on  = 1'b0;
  logic [7:0] alias_base = 8'hFF;
  logic       stuck_on  = 1'b0;
  logic [7:0] stuck_page = 8'h00;
  logic [7:0] zp_init   = 8'h00;

  logic [7:0] pg0 [256];
  logic [7:0] bus_last = 8'h00;

  // access log
  logic [15:0] log_addr [8];
  logic        log_we   [8];
  logic [7:0]  log_data [8];
  int          log_n = 0;
  int          zero_wr_n = 0;
  int          req_n = 0;
  logic [255:0] wrote_b = '0;

  always #4 clk = ~clk;

  mem_size_probe u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .done_o(done), .top_page_o(top)
  );

  always @(posedge clk) begin : mem_model
    logic [15:0] phys;
    logic [7:0]  pg;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) pg0[i] <= 8'h00;
      pg0[0]    <= zp_init;
      log_n     <= 0;
      zero_wr_n <= 0;
      wrote_b   <= '0;
    end else if (req) begin
      req_n <= req_n + 1;
      if (log_n < 8) begin
        log_addr[log_n] <= addr;
        log_we[log_n]   <= we;
        log_data[log_n] <= wdata;
        log_n <= log_n + 1;
      end
      if (we && addr == 16'h0000) zero_wr_n <= zero_wr_n + 1;
      if (we && addr != 16'h0000 && wdata == 8'h55) wrote_b[addr[15:8]] <= 1'b1;
      phys = (alias_on && addr[15:8] >= alias_base) ? {8'h00, addr[7:0]} : addr;
      pg   = phys[15:8];
      if (we) begin
        bus_last <= wdata;
        if (pg <= pop_top && phys[7:0] == 8'h00)
          pg0[pg] <= (stuck_on && pg == stuck_page) ? (wdata & 8'hFE) : wdata;
      end else if (pg <= pop_top) begin
        rdata    <= pg0[pg];
        bus_last <= pg0[pg];
      end else begin
        rdata <= bus_last;
      end
    end
  end

  task automatic check(input bit ok, input string req_id, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_id, act, exp);
    end
  endtask

  task automatic run_probe(input logic [7:0] pt, input bit al, input logic [7:0] ab,
                           input bit st, input logic [7:0] sp, input logic [7:0] zi);
    @(negedge clk);
    rst_n = 1'b0;
    pop_top = pt; alias_on = al; alias_base = ab;
    stuck_on = st; stuck_page = sp; zp_init = zi;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10000 && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && req == 1'b0, "R7 reset idle", {done, req}, 0);
  endtask

  task automatic t_first_accesses();
    run_probe(8'h1F, 0, 8'hFF, 0, 8'h00, 8'hFF);
    check(log_we[0] && log_addr[0] == 16'h1800 && log_data[0] == 8'hAA,
          "R1 first write", int'(log_addr[0]), 16'h1800);
    check(!log_we[1] && log_addr[1] == 16'h0000, "R3 trip read", int'(log_addr[1]), 0);
    check(log_we[2] && log_addr[2] == 16'h0000 && log_data[2] == 8'hFF,
          "R3 old value write", int'(log_data[2]), 8'hFF);
    check(log_we[3] && log_addr[3] == 16'h0000 && log_data[3] == 8'h00,
          "R3 incremented write", int'(log_data[3]), 8'h00);
    check(!log_we[4] && log_addr[4] == 16'h1800, "R2 readback", int'(log_addr[4]), 16'h1800);
    check(done && top == 8'h1F, "R5 top after fail", int'(top), 8'h1F);
    check(!wrote_b[8'h20], "R4 no second pattern after mismatch", int'(wrote_b[8'h20]), 0);
  endtask

  task automatic t_hold_and_restart();
    int n0;
    logic [7:0] t0;
    n0 = req_n; t0 = top;
    repeat (40) @(negedge clk);
    check(done && top == t0 && req_n == n0, "R7 hold while done", req_n - n0, 0);
    pop_top = 8'h25;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done, "R8 done drops on start", int'(done), 0);
    for (int i = 0; i < 10000 && !done; i++) @(negedge clk);
    check(done && top == 8'h25, "R8 rerun result", int'(top), 8'h25);
  endtask

  task automatic t_first_page_fail();
    run_probe(8'h17, 0, 8'hFF, 0, 8'h00, 8'h00);
    check(done && top == 8'h17, "R5 first page fails", int'(top), 8'h17);
  endtask

  task automatic t_full_map();
    run_probe(8'hFF, 0, 8'hFF, 0, 8'h00, 8'h00);
    check(done && top == 8'hFF, "R6 full map top", int'(top), 8'hFF);
    check(zero_wr_n == 2 * 2 * (8'hFF - 8'h17), "R6 no wrap zero writes",
          zero_wr_n, 2 * 2 * (8'hFF - 8'h17));
  endtask

  task automatic t_residue();
    run_probe(8'h3F, 0, 8'hFF, 0, 8'h00, 8'hFF);
    check(done && top == 8'h3F, "R9 bus residue", int'(top), 8'h3F);
  endtask

  task automatic t_alias();
    run_probe(8'hFF, 1, 8'h40, 0, 8'h00, 8'h00);
    check(done && top == 8'h3F, "R10 zero page alias", int'(top), 8'h3F);
  endtask

  task automatic t_stuck_bit();
    run_probe(8'hFF, 0, 8'hFF, 1, 8'h30, 8'h00);
    check(done && top == 8'h2F, "R4 stuck bit caught by second pattern", int'(top), 8'h2F);
    check(wrote_b[8'h30] == 1'b1, "R4 second pattern written", int'(wrote_b[8'h30]), 1);
  endtask

  initial begin
    t_reset_state();
    t_first_accesses();
    t_hold_and_restart();
    t_first_page_fail();
    t_full_map();
    t_residue();
    t_alias();
    t_stuck_bit();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule